// File: doc/BRIEF.md
# Indirect Flash Access and Erase/Program Sequencer

This block is the CPU-facing front end of an on-chip flash array. Software does not map the array directly. It loads a page index, a row index and a column index into three address registers. It then moves bytes through a single data port. Every accepted data-port read or write advances the composite address by one, so a whole row or page can be streamed through one register location.

A control register launches one of three operations: a mass erase, an erase of one 2 KB page, or programming of one row. A cycle counter times each operation, and the durations are parameters counted in clock cycles. While an operation runs, the block reports busy. It also raises a wait line that stalls the CPU when the CPU touches flash, through the data port or through its flash memory window. Accesses elsewhere continue without a stall. The erase command bits clear themselves when the erase ends. A row program that does not reach the last column before its time limit ends with a timeout flag.

The address arithmetic covers a 256 KB main array, with 256-byte rows and eight rows per page, which gives 128 pages. A separate 512-byte information page is selected by the top bit of the page register.

Top module: `flash_ctl_regif`

## Requirements
- R1: After reset, the page, row, column, control and status registers all read 0 and `cpu_wait` is low.
- R2: `reg_sel` selects the register. 0 is the page register, with {info-enable in bit 7, page index in bits 6:0}. 1 is the row register, in bits 2:0. 2 is the column register, 8 bits. 3 is the data port. 4 is the control register. 5 is the status register, with {timeout in bit 1, busy in bit 0}. The address registers read back what was written.
- R3: Every accepted read or write of the data port adds one to the 18-bit {page,row,col} address. The carry runs from column into row and from row into page, and page 127 wraps to 0. The info-enable bit does not change.
- R4: In the control register, bit 0 starts a mass erase, bit 1 a page erase and bit 2 a row program. When several bits are written together, mass erase wins over page erase, and page erase wins over row program. A command written while busy has no effect.
- R5: A mass erase stays busy for exactly MASS_CYC cycles after the write, and a page erase for exactly PAGE_CYC cycles. When the erase ends, its control bit reads back 0. The mass erase duration is the same with or without the information page.
- R6: A page erase sets all 2048 bytes of the page latched at the command to 0xFF. A mass erase sets the main array to 0xFF. The information page is erased only when info-enable was set when the command was written.
- R7: During an erase, any data-port access and any flash-window access (`mem_req` with `mem_flash`) raises `cpu_wait`. A non-flash access does not. While `cpu_wait` is high, no register write and no data-port access takes effect.
- R8: During a row program, data-port writes proceed without wait and store their bytes. Data-port reads and flash-window reads raise `cpu_wait`. Flash-window writes do not.
- R9: A data-port write at column 255 ends a row program at once with timeout 0. Otherwise the program ends after ROW_TMO cycles and sets timeout to 1. The next accepted command clears timeout.
- R10: A data-port write while no row program is running leaves flash unchanged, but it still advances the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| mem_req | input | 1 | CPU memory-space access in this cycle |
| mem_we | input | 1 | That memory access is a write |
| mem_flash | input | 1 | That memory access targets the flash window |
| cpu_wait | output | 1 | Stall request to the CPU |
| fl_addr | output | 18 | Array byte address {page,row,col} |
| fl_info | output | 1 | Array access targets the information page |
| fl_rd | output | 1 | Array read strobe |
| fl_wr | output | 1 | Array program strobe |
| fl_wdata | output | 8 | Array program data |
| fl_rdata | input | 8 | Array read data |
| fl_erase_mass | output | 1 | One-cycle mass erase strobe |
| fl_erase_page | output | 1 | One-cycle page erase strobe |
| fl_erase_info | output | 1 | Mass erase includes the information page |
| fl_erase_pg | output | 7 | Page index for the page erase |

## Verification
The bench builds the block with MASS_CYC=40, PAGE_CYC=12 and ROW_TMO=300. These values keep every erase window short enough to poll status cycle by cycle and to probe the stall logic during it. The row time limit still leaves room for a full 256-byte row program to finish by reaching column 255 before the timer runs out. A second, short row program that stops early then reaches the timeout path within a few hundred cycles.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;
  localparam logic [2:0] SEL_PAGE = 3'd0;
  localparam logic [2:0] SEL_ROW  = 3'd1;
  localparam logic [2:0] SEL_COL  = 3'd2;
  localparam logic [2:0] SEL_DATA = 3'd3;
  localparam logic [2:0] SEL_CTRL = 3'd4;
  localparam logic [2:0] SEL_STAT = 3'd5;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_MASS = 2'd1,
    OP_PAGE = 2'd2,
    OP_ROW  = 2'd3
  } flash_op_e;
endpackage

// File: rtl/flash_addr_ctr.sv
module flash_addr_ctr #(
  parameter int PAGE_W = 7,
  parameter int ROW_W  = 3,
  parameter int COL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_page,
  input  logic              wr_row,
  input  logic              wr_col,
  input  logic [7:0]        wdata,
  input  logic              step,
  output logic [PAGE_W-1:0] page,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col,
  output logic              info
);
  localparam int ADDR_W = PAGE_W + ROW_W + COL_W;

  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              info_q, info_n;
  logic [ADDR_W-1:0] addr_inc;

  assign addr_inc = addr_q + ADDR_W'(1);

  always_comb begin
    addr_n = addr_q;
    info_n = info_q;
    if (step) begin
      addr_n = addr_inc;
    end else if (wr_page) begin
      addr_n[ADDR_W-1 -: PAGE_W] = wdata[PAGE_W-1:0];
      info_n = wdata[7];
    end else if (wr_row) begin
      addr_n[COL_W +: ROW_W] = wdata[ROW_W-1:0];
    end else if (wr_col) begin
      addr_n[COL_W-1:0] = wdata[COL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      info_q <= 1'b0;
    end else begin
      addr_q <= addr_n;
      info_q <= info_n;
    end
  end

  assign page = addr_q[ADDR_W-1 -: PAGE_W];
  assign row  = addr_q[COL_W +: ROW_W];
  assign col  = addr_q[COL_W-1:0];
  assign info = info_q;

  AST_STEP_INCREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> addr_q == $past(addr_q) + ADDR_W'(1)) else $error("step"); // R3
  AST_STEP_KEEPS_INFO: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> $stable(info_q)) else $error("info"); // R3
endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
  import flash_ctl_pkg::*;
#(
  parameter int PAGE_W   = 7,
  parameter int MASS_CYC = 10_000_000,
  parameter int PAGE_CYC = 500_000,
  parameter int ROW_TMO  = 5_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [2:0]        cmd,
  input  logic              info_in,
  input  logic [PAGE_W-1:0] page_in,
  input  logic              row_done,
  output logic              busy,
  output flash_op_e         op,
  output logic              timeout,
  output logic              er_mass,
  output logic              er_page,
  output logic              er_info,
  output logic [PAGE_W-1:0] er_pg
);
  localparam int MAX_AB = (MASS_CYC > PAGE_CYC) ? MASS_CYC : PAGE_CYC;
  localparam int MAX_C  = (MAX_AB > ROW_TMO) ? MAX_AB : ROW_TMO;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  flash_op_e         op_q, op_n;
  logic              busy_q, busy_n;
  logic              tmo_q, tmo_n;
  logic              info_q, info_n;
  logic [PAGE_W-1:0] pg_q, pg_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              at_end;

  assign at_end = busy_q && (cnt_q == '0);

  always_comb begin
    op_n   = op_q;
    busy_n = busy_q;
    tmo_n  = tmo_q;
    info_n = info_q;
    pg_n   = pg_q;
    cnt_n  = cnt_q;
    if (busy_q) begin
      if (op_q == OP_ROW && row_done) begin
        busy_n = 1'b0;
        op_n   = OP_IDLE;
      end else if (cnt_q == '0) begin
        busy_n = 1'b0;
        op_n   = OP_IDLE;
        tmo_n  = (op_q == OP_ROW);
      end else begin
        cnt_n = cnt_q - CNT_W'(1);
      end
    end else if (cmd_wr && (cmd != 3'b000)) begin
      busy_n = 1'b1;
      tmo_n  = 1'b0;
      info_n = info_in;
      pg_n   = page_in;
      if (cmd[0]) begin
        op_n  = OP_MASS;
        cnt_n = CNT_W'(MASS_CYC - 1);
      end else if (cmd[1]) begin
        op_n  = OP_PAGE;
        cnt_n = CNT_W'(PAGE_CYC - 1);
      end else begin
        op_n  = OP_ROW;
        cnt_n = CNT_W'(ROW_TMO - 1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      busy_q <= 1'b0;
      tmo_q  <= 1'b0;
      info_q <= 1'b0;
      pg_q   <= '0;
      cnt_q  <= '0;
    end else begin
      op_q   <= op_n;
      busy_q <= busy_n;
      tmo_q  <= tmo_n;
      info_q <= info_n;
      pg_q   <= pg_n;
      cnt_q  <= cnt_n;
    end
  end

  assign busy    = busy_q;
  assign op      = op_q;
  assign timeout = tmo_q;
  assign er_mass = at_end && (op_q == OP_MASS);
  assign er_page = at_end && (op_q == OP_PAGE);
  assign er_info = info_q;
  assign er_pg   = pg_q;

  AST_ERASE_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (er_mass || er_page) |=> !busy_q && op_q == OP_IDLE) else $error("clear"); // R5
  AST_CMD_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0 && !(op_q == OP_ROW && row_done)) |=> busy_q && op_q == $past(op_q)) else $error("busy"); // R4
  AST_TMO_ONLY_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_q) |-> $past(op_q) == OP_ROW) else $error("tmo"); // R9
  AST_ROW_DONE_NO_TMO: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && op_q == OP_ROW && row_done) |=> !tmo_q && !busy_q) else $error("done"); // R9
endmodule

// File: rtl/flash_ctl_regif.sv
module flash_ctl_regif
  import flash_ctl_pkg::*;
#(
  parameter int MASS_CYC = 10_000_000,
  parameter int PAGE_CYC = 500_000,
  parameter int ROW_TMO  = 5_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_sel,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        mem_req,
  input  logic        mem_we,
  input  logic        mem_flash,
  output logic        cpu_wait,
  output logic [17:0] fl_addr,
  output logic        fl_info,
  output logic        fl_rd,
  output logic        fl_wr,
  output logic [7:0]  fl_wdata,
  input  logic [7:0]  fl_rdata,
  output logic        fl_erase_mass,
  output logic        fl_erase_page,
  output logic        fl_erase_info,
  output logic [6:0]  fl_erase_pg
);
  localparam int PAGE_W = 7;
  localparam int ROW_W  = 3;
  localparam int COL_W  = 8;

  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic [PAGE_W-1:0] page;
  logic [ROW_W-1:0]  row;
  logic [COL_W-1:0]  col;
  logic              info;
  logic              busy, timeout;
  flash_op_e         op;
  logic              data_rd, data_wr, fl_win_rd, fl_win_wr;
  logic              erase_run, row_run;
  logic              acc_ok, step, row_done;

  assign data_rd   = reg_rd && (reg_sel == SEL_DATA);
  assign data_wr   = reg_wr && (reg_sel == SEL_DATA);
  assign fl_win_rd = mem_req && mem_flash && !mem_we;
  assign fl_win_wr = mem_req && mem_flash && mem_we;
  assign erase_run = busy && (op == OP_MASS || op == OP_PAGE);
  assign row_run   = busy && (op == OP_ROW);

  always_comb begin
    cpu_wait = 1'b0;
    if (erase_run)    cpu_wait = data_rd || data_wr || fl_win_rd || fl_win_wr;
    else if (row_run) cpu_wait = data_rd || fl_win_rd;
  end

  assign acc_ok   = !cpu_wait;
  assign step     = acc_ok && (data_rd || data_wr);
  assign fl_wr    = acc_ok && data_wr && row_run;
  assign fl_rd    = acc_ok && data_rd;
  assign row_done = fl_wr && (col == {COL_W{1'b1}});

  flash_addr_ctr #(.PAGE_W(PAGE_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .wr_page (acc_ok && reg_wr && reg_sel == SEL_PAGE),
    .wr_row  (acc_ok && reg_wr && reg_sel == SEL_ROW),
    .wr_col  (acc_ok && reg_wr && reg_sel == SEL_COL),
    .wdata   (reg_wdata),
    .step    (step),
    .page    (page),
    .row     (row),
    .col     (col),
    .info    (info)
  );

  flash_op_seq #(
    .PAGE_W   (PAGE_W),
    .MASS_CYC (MASS_CYC),
    .PAGE_CYC (PAGE_CYC),
    .ROW_TMO  (ROW_TMO)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .cmd_wr   (acc_ok && reg_wr && reg_sel == SEL_CTRL),
    .cmd      (reg_wdata[2:0]),
    .info_in  (info),
    .page_in  (page),
    .row_done (row_done),
    .busy     (busy),
    .op       (op),
    .timeout  (timeout),
    .er_mass  (fl_erase_mass),
    .er_page  (fl_erase_page),
    .er_info  (fl_erase_info),
    .er_pg    (fl_erase_pg)
  );

  assign fl_addr  = {page, row, col};
  assign fl_info  = info;
  assign fl_wdata = reg_wdata;

  always_comb begin
    reg_rdata = 8'h00;
    case (reg_sel)
      SEL_PAGE: reg_rdata = {info, page};
      SEL_ROW:  reg_rdata = {{(8-ROW_W){1'b0}}, row};
      SEL_COL:  reg_rdata = col;
      SEL_DATA: reg_rdata = fl_rdata;
      SEL_CTRL: reg_rdata = {5'b0, op == OP_ROW && busy, op == OP_PAGE && busy, op == OP_MASS && busy};
      SEL_STAT: reg_rdata = {6'b0, timeout, busy};
      default:  reg_rdata = 8'h00;
    endcase
  end

  AST_WAIT_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_i_n)
    cpu_wait |-> busy) else $error("wait"); // R7
  AST_NO_STEP_ON_WAIT: assert property (@(posedge clk) disable iff (!rst_i_n)
    cpu_wait |=> $stable(fl_addr) && $stable(fl_info)) else $error("stall"); // R7
  AST_NONFLASH_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mem_req && !mem_flash && !reg_rd && !reg_wr) |-> !cpu_wait) else $error("nonflash"); // R7
  AST_ROW_WRITE_FLOWS: assert property (@(posedge clk) disable iff (!rst_i_n)
    (row_run && data_wr && !mem_req) |-> !cpu_wait && fl_wr) else $error("rowwr"); // R8
  AST_NO_PROG_IDLE: assert property (@(posedge clk) disable iff (!rst_i_n)
    fl_wr |-> busy && op == OP_ROW) else $error("prog"); // R10
endmodule

// File: tb/flash_ctl_regif_bench.sv
module flash_ctl_regif_bench;
  localparam int MASS = 40;
  localparam int PGC  = 12;
  localparam int TMO  = 300;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  reg_sel;
  logic        reg_wr, reg_rd, mem_req, mem_we, mem_flash;
  logic [7:0]  reg_wdata, reg_rdata, fl_wdata, fl_rdata;
  logic        cpu_wait, fl_info, fl_rd, fl_wr;
  logic [17:0] fl_addr;
  logic        fl_erase_mass, fl_erase_page, fl_erase_info;
  logic [6:0]  fl_erase_pg;

  always #4 clk = ~clk;

  flash_ctl_regif #(.MASS_CYC(MASS), .PAGE_CYC(PGC), .ROW_TMO(TMO)) u_flash_ctl_regif (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_flash(mem_flash), .cpu_wait(cpu_wait), .fl_addr(fl_addr), .fl_info(fl_info),
    .fl_rd(fl_rd), .fl_wr(fl_wr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
    .fl_erase_mass(fl_erase_mass), .fl_erase_page(fl_erase_page),
    .fl_erase_info(fl_erase_info), .fl_erase_pg(fl_erase_pg)
  );

  int n_vec = 0, n_bad = 0, cyc_cnt = 0;
  bit done = 0;

  // array contents seen by the design, and the reference model
  byte unsigned fmem[int];
  byte unsigned mmem[int];

  int m_pg, m_row, m_col, m_op, m_cnt;
  bit m_info, m_busy, m_tmo, m_einfo;
  int m_epg;

  function automatic int key_of(bit inf, int a);
    return inf ? ((1 << 18) | (a & 511)) : a;
  endfunction

  function automatic int m_addr();
    return (m_pg << 11) | (m_row << 8) | m_col;
  endfunction

  task automatic check(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc_cnt);
    end
  endtask

  task automatic erase_f(bit mass, bit inf, int pg);
    int ks[$];
    foreach (fmem[k]) if (mass ? (inf || k < (1 << 18)) : (k >= pg * 2048 && k < pg * 2048 + 2048)) ks.push_back(k);
    foreach (ks[i]) fmem.delete(ks[i]);
  endtask

  task automatic erase_m(bit mass, bit inf, int pg);
    int ks[$];
    foreach (mmem[k]) if (mass ? (inf || k < (1 << 18)) : (k >= pg * 2048 && k < pg * 2048 + 2048)) ks.push_back(k);
    foreach (ks[i]) mmem.delete(ks[i]);
  endtask

  task automatic cyc(input logic [2:0] sel, input bit wr, input bit rd, input logic [7:0] wd,
                     input bit mq, input bit mw, input bit mf, input string req);
    bit ew, done_row, ended;
    int exp_rd, k;
    bit s_wr, s_em, s_ep, s_ei;
    int s_key, s_pg;
    byte unsigned s_wd;
    @(negedge clk);
    reg_sel = sel; reg_wr = wr; reg_rd = rd; reg_wdata = wd;
    mem_req = mq; mem_we = mw; mem_flash = mf;
    #1;
    k = key_of(fl_info, int'(fl_addr));
    fl_rdata = fmem.exists(k) ? fmem[k] : 8'hFF;
    #1;
    ew = 0;
    if (m_busy && m_op != 3) ew = (sel == 3 && (rd || wr)) || (mq && mf);
    if (m_busy && m_op == 3) ew = (sel == 3 && rd) || (mq && mf && !mw);
    check({req, "/wait"}, cpu_wait, ew);
    if (rd && !ew) begin
      case (sel)
        0: exp_rd = {m_info, 7'(m_pg)};
        1: exp_rd = m_row;
        2: exp_rd = m_col;
        3: exp_rd = mmem.exists(key_of(m_info, m_addr())) ? mmem[key_of(m_info, m_addr())] : 8'hFF;
        4: exp_rd = m_busy ? (1 << (m_op - 1)) : 0;
        5: exp_rd = {m_tmo, m_busy};
        default: exp_rd = 0;
      endcase
      check({req, "/rdata"}, reg_rdata, exp_rd);
    end
    s_wr = fl_wr; s_key = key_of(fl_info, int'(fl_addr)); s_wd = fl_wdata;
    s_em = fl_erase_mass; s_ep = fl_erase_page; s_ei = fl_erase_info; s_pg = fl_erase_pg;
    @(posedge clk);
    if (s_wr) fmem[s_key] = s_wd;
    if (s_em || s_ep) erase_f(s_em, s_ei, s_pg);
    // reference model step
    done_row = 0;
    ended = 0;
    if (m_busy) begin
      if (!ew && wr && sel == 3 && m_op == 3 && m_col == 255) done_row = 1;
      if (done_row) begin m_busy = 0; ended = 1; end
      else if (m_cnt == 0) begin
        if (m_op == 1) erase_m(1, m_einfo, 0);
        if (m_op == 2) erase_m(0, 0, m_epg);
        m_tmo = (m_op == 3);
        m_busy = 0; ended = 1;
      end else m_cnt--;
    end
    if (!ew) begin
      if (wr && sel == 3 && m_busy && m_op == 3) mmem[key_of(m_info, m_addr())] = wd;
      if (wr && sel == 3 && ended && done_row) mmem[key_of(m_info, m_addr())] = wd;
      if (wr && sel == 4 && !m_busy && !ended && wd[2:0] != 0) begin
        m_op = wd[0] ? 1 : (wd[1] ? 2 : 3);
        m_cnt = (m_op == 1 ? MASS : (m_op == 2 ? PGC : TMO)) - 1;
        m_busy = 1; m_tmo = 0; m_einfo = m_info; m_epg = m_pg;
      end
      if (wr && sel == 0) begin m_info = wd[7]; m_pg = wd[6:0]; end
      if (wr && sel == 1) m_row = wd[2:0];
      if (wr && sel == 2) m_col = wd;
      if ((wr || rd) && sel == 3) begin
        int a = (m_addr() + 1) & 18'h3FFFF;
        m_pg = a >> 11; m_row = (a >> 8) & 7; m_col = a & 255;
      end
    end
  endtask

  task automatic idle(string req); cyc(0, 0, 0, 0, 0, 0, 0, req); endtask
  task automatic wreg(logic [2:0] s, logic [7:0] d, string req); cyc(s, 1, 0, d, 0, 0, 0, req); endtask
  task automatic rreg(logic [2:0] s, string req); cyc(s, 0, 1, 0, 0, 0, 0, req); endtask
  task automatic seta(int pg, int rw, int cl, bit inf);
    wreg(0, {inf, 7'(pg)}, "R2"); wreg(1, 8'(rw), "R2"); wreg(2, 8'(cl), "R2");
  endtask
  task automatic read_addr(string req); rreg(0, req); rreg(1, req); rreg(2, req); endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc_cnt++;
      if (cyc_cnt > 100000) begin
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc_cnt);
        done = 1;
      end
    end
  end

  initial begin
    rst_n = 0; reg_sel = 0; reg_wr = 0; reg_rd = 0; reg_wdata = 0;
    mem_req = 0; mem_we = 0; mem_flash = 0; fl_rdata = 8'hFF;
    m_pg = 0; m_row = 0; m_col = 0; m_op = 0; m_cnt = 0;
    m_info = 0; m_busy = 0; m_tmo = 0; m_einfo = 0; m_epg = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    // R1 reset values
    read_addr("R1"); rreg(4, "R1"); rreg(5, "R1");
    // R2 readback, R3 carries column->row->page and page wrap
    seta(3, 7, 254, 0); read_addr("R2");
    rreg(3, "R3"); rreg(3, "R3"); read_addr("R3");
    seta(127, 7, 255, 1); rreg(3, "R3"); read_addr("R3");
    // R10 write outside programming: address steps, array untouched
    seta(5, 2, 9, 0); wreg(3, 8'h12, "R10"); read_addr("R10");
    wreg(2, 9, "R10"); rreg(3, "R10");
    // R8/R9 full row program finishing at column 255
    seta(2, 1, 0, 0); wreg(4, 8'h04, "R8"); rreg(5, "R8"); rreg(4, "R8");
    for (int i = 0; i < 256; i++) begin
      if (i == 5) begin
        rreg(3, "R8"); cyc(0, 0, 0, 0, 1, 0, 1, "R8"); cyc(0, 0, 0, 0, 1, 1, 1, "R8");
        cyc(0, 0, 0, 0, 1, 0, 0, "R8");
      end
      wreg(3, 8'(i * 3 + 1), "R8");
    end
    rreg(5, "R9"); read_addr("R3");
    seta(2, 1, 0, 0);
    for (int i = 0; i < 8; i++) rreg(3, "R8");
    seta(2, 1, 250, 0);
    for (int i = 0; i < 6; i++) rreg(3, "R8");
    // R9 timeout path, on the information page
    seta(0, 0, 0, 1); wreg(4, 8'h04, "R9"); wreg(3, 8'hAA, "R9"); wreg(3, 8'hBB, "R9");
    for (int i = 0; i < TMO + 2; i++) rreg(5, "R9");
    seta(0, 0, 0, 1); rreg(3, "R9"); rreg(3, "R9");
    // R5/R6/R7 page erase; R4 command during busy is ignored
    seta(2, 0, 0, 0); wreg(4, 8'h02, "R5"); rreg(4, "R4");
    wreg(4, 8'h01, "R4"); rreg(4, "R4");
    cyc(3, 1, 0, 8'h55, 0, 0, 0, "R7"); cyc(3, 0, 1, 0, 0, 0, 0, "R7");
    cyc(0, 0, 0, 0, 1, 1, 1, "R7"); cyc(0, 0, 0, 0, 1, 0, 0, "R7");
    cyc(2, 1, 0, 8'h33, 1, 0, 1, "R7");
    for (int i = 0; i < PGC; i++) rreg(5, "R5");
    rreg(4, "R5"); rreg(5, "R9"); read_addr("R7");
    seta(2, 1, 0, 0); rreg(3, "R6"); rreg(3, "R6");
    seta(5, 2, 9, 0); rreg(3, "R6");
    // R4 priority: all bits set, info off -> mass erase of main only
    seta(0, 0, 0, 0); wreg(4, 8'h07, "R4"); rreg(4, "R4");
    for (int i = 0; i < MASS; i++) rreg(5, "R5");
    seta(0, 0, 0, 1); rreg(3, "R6"); rreg(3, "R6");
    // mass erase with information page enabled
    wreg(4, 8'h01, "R6");
    for (int i = 0; i < MASS; i++) rreg(5, "R5");
    seta(0, 0, 0, 1); rreg(3, "R6"); rreg(3, "R6");
    idle("R1");
    done = 1;
    #20;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    wait (done);
    #10;
  end
endmodule